// File: doc/BRIEF.md
# SRAM Stream Wrapper

This block places a single-port, synchronous-read memory of 128 words by 32 bits behind two valid/ready streams. A consumer sends requests on the request stream. Each request carries a read/write kind, an 8-bit tag that the block does not interpret, a byte address and a data word. The block answers each request with one response on the response stream. A response carries the same kind and tag. For a read it also carries the stored word; for a write it carries zero.

Work flows through three stages. In the accept stage the handshake completes and the memory access starts. In the capture stage the memory's read data arrives and the response is formed. In the output stage the response either passes straight to the response port or waits in a small queue. A memory access that has started cannot be paused. For that reason the request side takes a new request only when the queue has room for both the response in the capture stage and the request being accepted now. Back-pressure on the response stream therefore stops new requests early, and no response is ever lost.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, the response payload holds steady.

Top module: `sram_stream_wrapper`

## Requirements
- R1: During a synchronous active-high reset, and after it, the queue and the stage-valid bits are cleared. The first cycle after reset shows `rsp_valid` = 0 and `req_ready` = 1. Memory contents are not cleared.
- R2: A read (kind 0) returns the word most recently written to the same word index, together with the request's tag. The word index is address bits [8:2]. The two low bits and all bits above bit 8 are ignored, so 0x006 and 0x205 both select word 1, and 0x3FC selects word 127.
- R3: A write (kind 1) stores the data word at the indexed word. Its response carries kind 1, the request's tag and data 0.
- R4: Responses leave in the order the requests were accepted. None is lost or duplicated under any pattern of stalls on either stream.
- R5: `req_ready` is high only when at least two queue entries are free. With the response stream held stalled from an idle state, exactly two requests are accepted before `req_ready` falls.
- R6: When the queue is empty and `rsp_ready` is high, the response to a request accepted at a clock edge appears on the response port in the cycle right after that edge, bypassing the queue.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and the response payload does not change on the next edge.
- R8: `req_ready` depends only on the queue occupancy held in registers. Raising `rsp_ready` while the queue is full does not raise `req_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_kind | input | 1 | Request kind: 0 read, 1 write |
| req_tag | input | 8 | Opaque request tag |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Write data |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_kind | output | 1 | Response kind, copied from the request |
| rsp_tag | output | 8 | Response tag, copied from the request |
| rsp_data | output | 32 | Read word, or zero for a write |

## Verification
The hardest case to reach is the one the early ready rule exists for. A response must stall while one request sits in the capture stage and a second is being accepted in the same edge; both must then land in the queue. The bench reaches this by holding `rsp_ready` low from an idle state while it offers requests back to back. It then counts the accepted requests and checks that the first response holds still. Next it raises `rsp_ready` while the queue is full, to show that ready does not follow it within the cycle. Random stalls on the response side during a mixed read/write stream also cover the bypass and queued paths against a reference memory.

// File: rtl/sramw_pkg.sv
`timescale 1ns/1ps
package sramw_pkg;
  // Request/response kind encoding
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  // Number of byte-offset bits below the word index
  localparam int unsigned BYTE_OFS = 2;
endpackage

// File: rtl/sramw_array.sv
`timescale 1ns/1ps
module sramw_array #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [WORDS];

  // One access per cycle; read data registered, valid the following cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (wr) cells[idx] <= wdata;
      else    rdata      <= cells[idx];
    end
  end
endmodule

// File: rtl/sramw_respq.sv
`timescale 1ns/1ps
module sramw_respq #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 41,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enq_valid,
  input  logic [W-1:0] enq_data,
  output logic         deq_valid,
  input  logic         deq_ready,
  output logic [W-1:0] deq_data,
  output logic         room2
);
  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;
  logic             empty, bypass, do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt == '0);
  assign deq_valid = !empty || enq_valid;
  assign deq_data  = empty ? enq_data : slot[head];
  assign bypass    = empty && enq_valid && deq_ready;
  assign do_push   = enq_valid && !bypass;
  assign do_pop    = !empty && deq_ready;
  // Registered occupancy only: an entry leaving this cycle still counts
  assign room2     = (cnt <= CNT_W'(DEPTH - 2));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && tail == PTR_W'(i)) slot[i] <= enq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) tail <= step(tail);
      if (do_pop)  head <= step(head);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(enq_valid && cnt == CNT_W'(DEPTH))); // R4
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_data))); // R7
  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (empty && enq_valid && deq_ready) |=> (cnt == '0)); // R6
endmodule

// File: rtl/sram_stream_wrapper.sv
`timescale 1ns/1ps
module sram_stream_wrapper #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QDEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_kind,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  import sramw_pkg::*;

  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned RSP_W = 1 + TAG_W + DATA_W;

  // Accept stage
  logic             fire;
  logic [IDX_W-1:0] idx_a;
  logic             addr_unused;

  assign fire        = req_valid && req_ready;
  assign idx_a       = req_addr[BYTE_OFS +: IDX_W];
  assign addr_unused = ^{req_addr[ADDR_W-1:BYTE_OFS+IDX_W], req_addr[BYTE_OFS-1:0]};

  // Capture stage
  logic              cap_valid;
  logic              cap_kind;
  logic [TAG_W-1:0]  cap_tag;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] cap_data;
  logic [RSP_W-1:0]  cap_rsp, out_rsp;

  sramw_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .en    (fire),
    .wr    (req_kind == OP_WRITE),
    .idx   (idx_a),
    .wdata (req_data),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= fire;
    end
    if (fire) begin
      cap_kind <= req_kind;
      cap_tag  <= req_tag;
    end
  end

  assign cap_data = (cap_kind == OP_WRITE) ? '0 : mem_rdata;
  assign cap_rsp  = {cap_kind, cap_tag, cap_data};

  // Output stage
  sramw_respq #(.DEPTH(QDEPTH), .W(RSP_W)) u_respq (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (cap_valid),
    .enq_data  (cap_rsp),
    .deq_valid (rsp_valid),
    .deq_ready (rsp_ready),
    .deq_data  (out_rsp),
    .room2     (req_ready)
  );

  assign {rsp_kind, rsp_tag, rsp_data} = out_rsp;

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == OP_WRITE) |-> (rsp_data == '0)); // R3
  AST_CAPTURE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid); // R6
  AST_STALL_STOPS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready && !req_ready) |=> !req_ready); // R5
endmodule

// File: tb/sram_stream_wrapper_tb.sv
`timescale 1ns/1ps
module sram_stream_wrapper_tb_top;
  localparam real CYC = 20.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_kind = 1'b0;
  logic [7:0]  req_tag = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_kind;
  logic [7:0]  rsp_tag;
  logic [31:0] rsp_data;

  always #(CYC/2) clk = ~clk;

  sram_stream_wrapper dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_tag(req_tag), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  int tests = 0;
  int fails = 0;
  int accepted = 0;
  int mode = 0;           // 0 always ready, 1 random, 2 held low
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] refm [128];
  logic        exp_kind [256];
  logic [7:0]  exp_tag  [256];
  logic [31:0] exp_data [256];
  int exp_wr = 0;
  int exp_rd = 0;

  // {kind, tag, addr, data}
  localparam logic [72:0] VEC [16] = '{
    {1'b1, 8'h01, 32'h000, 32'hA0A0_0001},
    {1'b1, 8'h02, 32'h1FC, 32'hB1B1_007F},
    {1'b1, 8'h03, 32'h004, 32'hC2C2_0011},
    {1'b1, 8'h04, 32'h008, 32'hD3D3_0002},
    {1'b0, 8'h05, 32'h000, 32'h0},
    {1'b0, 8'h06, 32'h1FC, 32'h0},
    {1'b0, 8'h07, 32'h205, 32'h0},
    {1'b0, 8'h08, 32'h00A, 32'h0},
    {1'b1, 8'h09, 32'h004, 32'h5555_AAAA},
    {1'b0, 8'h0A, 32'h006, 32'h0},
    {1'b1, 8'h0B, 32'h3FC, 32'h1234_5678},
    {1'b0, 8'h0C, 32'h1FD, 32'h0},
    {1'b0, 8'h0D, 32'h008, 32'h0},
    {1'b1, 8'h0E, 32'h00C, 32'hFFFF_0000},
    {1'b0, 8'h0F, 32'h00C, 32'h0},
    {1'b0, 8'h10, 32'h000, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Call just after a posedge; returns just after the edge where it fired
  task automatic send(input logic k, input logic [7:0] t, input logic [31:0] a, input logic [31:0] d);
    #2;
    req_valid = 1'b1; req_kind = k; req_tag = t; req_addr = a; req_data = d;
    do @(negedge clk); while (!req_ready);
    exp_kind[exp_wr[7:0]] = k;
    exp_tag[exp_wr[7:0]]  = t;
    if (k) begin
      refm[a[8:2]] = d;
      exp_data[exp_wr[7:0]] = '0;
    end else begin
      exp_data[exp_wr[7:0]] = refm[a[8:2]];
    end
    exp_wr++;
    accepted++;
    @(posedge clk);
  endtask

  task automatic idle_req;
    #2 req_valid = 1'b0;
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && exp_rd != exp_wr; i++) @(posedge clk);
    chk(exp_rd == exp_wr, "R4 all responses delivered", 32'(exp_rd), 32'(exp_wr));
  endtask

  // Response-side ready generator
  initial begin
    forever begin
      @(posedge clk);
      #2;
      case (mode)
        0:       rsp_ready = 1'b1;
        1:       rsp_ready = lfsr[0] | lfsr[3];
        default: rsp_ready = 1'b0;
      endcase
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  // Response monitor against the expected list (R2, R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid && rsp_ready) begin
        if (exp_rd >= exp_wr) begin
          chk(1'b0, "R4 unexpected response", {24'h0, rsp_tag}, 32'h0);
        end else begin
          chk(rsp_tag == exp_tag[exp_rd[7:0]], "R4 order tag",
              {24'h0, rsp_tag}, {24'h0, exp_tag[exp_rd[7:0]]});
          chk(rsp_kind == exp_kind[exp_rd[7:0]], "R4 kind echo",
              {31'h0, rsp_kind}, {31'h0, exp_kind[exp_rd[7:0]]});
          if (exp_kind[exp_rd[7:0]])
            chk(rsp_data == 32'h0, "R3 write response data", rsp_data, 32'h0);
          else
            chk(rsp_data == exp_data[exp_rd[7:0]], "R2 read data",
                rsp_data, exp_data[exp_rd[7:0]]);
          exp_rd++;
        end
      end
    end
  end

  initial begin
    #(CYC * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0]  held_tag;
    logic [31:0] held_data;
    // R1: reset state
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    @(posedge clk);

    // Seed a word, then R6: bypass latency with an empty queue
    send(1'b1, 8'h40, 32'h010, 32'h0BAD_F00D);
    send(1'b0, 8'h41, 32'h010, 32'h0);
    idle_req();
    @(negedge clk);
    chk(rsp_valid && rsp_tag == 8'h41, "R6 response one cycle after accept",
        {23'h0, rsp_valid, rsp_tag}, {23'h0, 1'b1, 8'h41});
    drain();

    // Main table under random response stalls (R2, R3, R4)
    mode = 1;
    @(posedge clk);
    foreach (VEC[i]) send(VEC[i][72], VEC[i][71:64], VEC[i][63:32], VEC[i][31:0]);
    idle_req();
    drain();

    // R5, R7, R8: stalled output from idle
    mode = 2;
    repeat (3) @(posedge clk);
    accepted = 0;
    fork
      begin
        send(1'b0, 8'h51, 32'h000, 32'h0);
        send(1'b0, 8'h52, 32'h1FC, 32'h0);
        send(1'b0, 8'h53, 32'h004, 32'h0);
        idle_req();
      end
      begin
        repeat (5) @(negedge clk);
        held_tag  = rsp_tag;
        held_data = rsp_data;
        @(negedge clk);
        chk(accepted == 2, "R5 accepted while stalled", 32'(accepted), 32'd2);
        chk(req_ready == 1'b0, "R5 ready low when full", {31'h0, req_ready}, 32'h0);
        chk(rsp_valid && rsp_tag == 8'h51, "R7 oldest response held",
            {23'h0, rsp_valid, rsp_tag}, {23'h0, 1'b1, 8'h51});
        chk(rsp_tag == held_tag && rsp_data == held_data, "R7 payload stable",
            rsp_data, held_data);
        mode = 0;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_ready == 1'b1, "R8 setup rsp_ready high", {31'h0, rsp_ready}, 32'h1);
        chk(req_ready == 1'b0, "R8 ready not combinational on rsp_ready",
            {31'h0, req_ready}, 32'h0);
      end
    join
    drain();

    repeat (5) @(posedge clk);
    finish_up();
  end
endmodule